// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Ready Flags

This block is a first-in first-out word buffer that a producer fills and a consumer drains through level strobes instead of clock enables. Each strobe is used on both of its edges. Raising `shift_in` loads the word on `din`, and lowering it commits that word. Raising `shift_out` acknowledges the word on `dout`, and lowering it releases that word and moves to the next one. Two flags carry the handshake. `in_rdy` reports that a free location can take a word. `out_rdy` reports that a valid word is being presented.

Both strobes are asynchronous to the block. Each one passes through a synchroniser chain on the single system clock, and the edge detection happens after that chain. After every commit, both flags hold their value for a programmable number of clock cycles, `FLAG_DLY`, and then settle. This models the propagation time of the ready flags. A producer that holds `shift_in` high against a full buffer has its word taken as soon as a read frees a location. `out_en` low forces `dout` to all zeros, so the outputs of several buffers can be OR-combined on one bus.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, the buffer is empty: `in_rdy`=1, `out_rdy`=0 and `dout`=0. This applies whether reset is applied at power-up or in the middle of operation.
- R2: Raising `shift_in` while `in_rdy`=1 captures `din`. `in_rdy` reads 0 three clock cycles after the raise.
- R3: Lowering `shift_in` after a capture commits the word. `in_rdy` stays 0 through cycle FLAG_DLY+3 after the lowering and equals 1 in cycle FLAG_DLY+4 if a location is still free.
- R4: A word committed into an empty buffer is driven on `dout`. `out_rdy` rises in cycle FLAG_DLY+4 after `shift_in` is lowered and stays 0 in the cycle before.
- R5: While `shift_out` is high, `out_rdy` is forced to 0. It reads 0 three cycles after `shift_out` rises.
- R6: Lowering `shift_out` after an acknowledged word releases that word. `out_rdy` stays 0 through cycle FLAG_DLY+3 and in cycle FLAG_DLY+4 equals 1 if a word remains, or 0 if the buffer is now empty.
- R7: The buffer never holds more than DEPTH words. Once DEPTH words are stored, `in_rdy` stays 0 and a held `shift_in` takes nothing.
- R8: If `shift_in` is held high while the buffer is full, the pending word is captured automatically after a read frees a location. It then leaves the buffer after all older words.
- R9: With `out_en`=0, `dout` is all zeros while `out_rdy` and the stored words are unaffected. Setting `out_en`=1 restores the presented word.
- R10: Words leave in the order they were written, including after the pointers wrap around the storage.
- R11: A `shift_out` pulse while the buffer is empty has no effect. `out_rdy` stays 0, and the next word written is the first word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Write strobe; rising edge loads, falling edge commits |
| shift_out | input | 1 | Read strobe; rising edge acknowledges, falling edge releases |
| out_en | input | 1 | Output enable; low forces `dout` to zero |
| din | input | DATA_W | Word to be written |
| dout | output | DATA_W | Oldest stored word, zero when empty or disabled |
| in_rdy | output | 1 | Space available for a new word |
| out_rdy | output | 1 | Valid word presented on `dout` |

## Verification
With the default chain of two synchroniser stages, a strobe change reaches the control logic on the third rising edge after it is driven. The flag reactions tied to a rising strobe are therefore due three cycles after the change. The commit on a falling strobe lands on that same third edge, and both flags then settle FLAG_DLY+1 edges later, so they are due in cycle FLAG_DLY+4. The bench drives inputs and samples outputs on falling clock edges. It checks each flag one cycle before its due cycle, where it must still hold its old value, and again in the due cycle, where it must have its new value. The flag reactions to a strobe are therefore checked in exact cycles, not by polling.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Synchronised view of one strobe: its settled level and a one-cycle
    // pulse marking the high-to-low transition.
    typedef struct packed {
        logic level;
        logic fall;
    } strobe_ev_t;

    // Advance a storage index by one, wrapping at the configured depth
    // (depth need not be a power of two).
    function automatic int unsigned wrap_next(int unsigned p, int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   strobe,
    output sfifo_pkg::strobe_ev_t  ev
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], strobe};
            last  <= chain[STAGES-1];
        end
    end

    assign ev.level = chain[STAGES-1];
    assign ev.fall  = ~chain[STAGES-1] & last;

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
    parameter int DEPTH    = 16,
    parameter int FLAG_DLY = 2,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int TW      = $clog2(FLAG_DLY + 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sfifo_pkg::strobe_ev_t si_ev,
    input  sfifo_pkg::strobe_ev_t so_ev,
    output logic                  wr_en,
    output logic [AW-1:0]         wr_addr,
    output logic [AW-1:0]         rd_addr,
    output logic [CW-1:0]         count,
    output logic                  in_rdy,
    output logic                  out_rdy
);
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count_n;
    logic [TW-1:0] settle;
    logic          wr_pend, rd_armed;
    logic          capture, wr_commit, rd_commit, any_commit;

    assign capture    = si_ev.level & in_rdy & ~wr_pend;
    assign wr_commit  = si_ev.fall & wr_pend;
    assign rd_commit  = so_ev.fall & rd_armed;
    assign any_commit = wr_commit | rd_commit;

    always_comb begin
        count_n = count;
        if (wr_commit && !rd_commit)      count_n = count + 1'b1;
        else if (!wr_commit && rd_commit) count_n = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            wr_pend  <= 1'b0;
            rd_armed <= 1'b0;
            settle   <= '0;
            in_rdy   <= 1'b1;
            out_rdy  <= 1'b0;
        end else begin
            count <= count_n;

            if (capture) begin
                wr_pend <= 1'b1;
            end else if (wr_commit) begin
                wr_pend <= 1'b0;
                wptr    <= AW'(sfifo_pkg::wrap_next(32'(wptr), DEPTH));
            end

            if (so_ev.level && out_rdy) begin
                rd_armed <= 1'b1;
            end else if (rd_commit) begin
                rd_armed <= 1'b0;
                rptr     <= AW'(sfifo_pkg::wrap_next(32'(rptr), DEPTH));
            end

            if (any_commit)          settle <= TW'(FLAG_DLY);
            else if (settle != '0)   settle <= settle - 1'b1;

            if (capture)                          in_rdy <= 1'b0;
            else if (!any_commit && settle == '0) in_rdy <= ~wr_pend & (count < CW'(DEPTH));

            if (so_ev.level)                      out_rdy <= 1'b0;
            else if (!any_commit && settle == '0) out_rdy <= (count != '0);
        end
    end

    assign wr_en   = capture;
    assign wr_addr = wptr;
    assign rd_addr = rptr;

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int FLAG_DLY    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_in,
    input  logic              shift_out,
    input  logic              out_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              in_rdy,
    output logic              out_rdy
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    sfifo_pkg::strobe_ev_t si_ev, so_ev;
    logic                  wr_en;
    logic [AW-1:0]         wr_addr, rd_addr;
    logic [CW-1:0]         count_w;
    logic [DATA_W-1:0]     rd_data, head_word;

    sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) u_si_sync (
        .clk(clk), .rst(rst), .strobe(shift_in), .ev(si_ev)
    );

    sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) u_so_sync (
        .clk(clk), .rst(rst), .strobe(shift_out), .ev(so_ev)
    );

    sfifo_ctrl #(.DEPTH(DEPTH), .FLAG_DLY(FLAG_DLY)) u_ctrl (
        .clk(clk), .rst(rst), .si_ev(si_ev), .so_ev(so_ev),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .count(count_w), .in_rdy(in_rdy), .out_rdy(out_rdy)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(din),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign head_word = (count_w != '0) ? rd_data : '0;
    assign dout      = out_en ? head_word : '0;

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CW     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              so_lvl,
    input logic              in_rdy,
    input logic              out_rdy,
    input logic [DATA_W-1:0] dout,
    input logic [CW-1:0]     count
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (in_rdy && !out_rdy && dout == '0)); // R1

    AST_SO_CLEARS_OR: assert property (@(posedge clk) disable iff (rst)
        so_lvl |=> !out_rdy); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R7

    AST_FULL_BLOCKS_IR: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |-> !in_rdy); // R7

    AST_EMPTY_NO_OR: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !out_rdy); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst || rst_q)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1
                  || count + 1'b1 == $past(count))); // R10

endmodule

bind strobe_fifo sfifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .so_lvl(so_ev.level), .in_rdy(in_rdy),
    .out_rdy(out_rdy), .dout(dout), .count(count_w)
);

// File: tb/strobe_fifo_test.sv
module strobe_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int DEP = 4;
    localparam int DLY = 2;
    localparam int NV  = 14;
    // bit 8: 1 = write the low byte, 0 = read and expect the low byte
    localparam logic [8:0] VEC [NV] = '{
        9'h111, 9'h122, 9'h133, 9'h011, 9'h144, 9'h155, 9'h022,
        9'h033, 9'h166, 9'h177, 9'h044, 9'h055, 9'h066, 9'h077
    };

    logic clk = 1'b0, rst = 1'b1, shift_in = 1'b0, shift_out = 1'b0, out_en = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic in_rdy, out_rdy;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] q [$];

    strobe_fifo #(.DATA_W(DW), .DEPTH(DEP), .FLAG_DLY(DLY), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .shift_in(shift_in), .shift_out(shift_out),
        .out_en(out_en), .din(din), .dout(dout), .in_rdy(in_rdy), .out_rdy(out_rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic push(logic [DW-1:0] d);
        int waited = 0;
        bit was_empty;
        while (!in_rdy && waited < 40) begin step(1); waited++; end
        chk(in_rdy == 1'b1, "R3 ready before write", int'(in_rdy), 1);
        was_empty = (q.size() == 0);
        din = d; shift_in = 1'b1;
        step(3);
        chk(in_rdy == 1'b0, "R2 in_rdy drops", int'(in_rdy), 0);
        shift_in = 1'b0;
        step(DLY + 3);
        chk(in_rdy == 1'b0, "R3 in_rdy still settling", int'(in_rdy), 0);
        if (was_empty) chk(out_rdy == 1'b0, "R4 out_rdy early", int'(out_rdy), 0);
        step(1);
        q.push_back(d);
        chk(in_rdy == (q.size() < DEP), "R3 R7 in_rdy after commit", int'(in_rdy), int'(q.size() < DEP));
        if (was_empty) begin
            chk(out_rdy == 1'b1, "R4 out_rdy rises", int'(out_rdy), 1);
            chk(dout == d, "R4 word presented", int'(dout), int'(d));
        end
    endtask

    task automatic pop(logic [DW-1:0] exp);
        chk(out_rdy == 1'b1, "R6 word ready", int'(out_rdy), 1);
        chk(dout == exp, "R10 order", int'(dout), int'(exp));
        shift_out = 1'b1;
        step(3);
        chk(out_rdy == 1'b0, "R5 out_rdy forced low", int'(out_rdy), 0);
        shift_out = 1'b0;
        step(DLY + 3);
        chk(out_rdy == 1'b0, "R6 out_rdy still settling", int'(out_rdy), 0);
        step(1);
        void'(q.pop_front());
        chk(out_rdy == (q.size() > 0), "R6 out_rdy after release", int'(out_rdy), int'(q.size() > 0));
        if (q.size() > 0) chk(dout == q[0], "R10 next word", int'(dout), int'(q[0]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        chk(in_rdy == 1'b1 && out_rdy == 1'b0 && dout == '0, "R1 reset state",
            int'({in_rdy, out_rdy}), 2);
        rst = 1'b0;
        step(1);
        chk(in_rdy == 1'b1 && out_rdy == 1'b0 && dout == '0, "R1 after release",
            int'({in_rdy, out_rdy}), 2);

        // table walk: fill, wrap, drain (R2 R3 R4 R5 R6 R7 R10)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][8]) push(VEC[i][DW-1:0]);
            else           pop(VEC[i][DW-1:0]);
        end

        // R9: output enable gating
        push(8'hA5);
        out_en = 1'b0; #1;
        chk(dout == '0, "R9 released when disabled", int'(dout), 0);
        chk(out_rdy == 1'b1, "R9 out_rdy unaffected", int'(out_rdy), 1);
        step(1);
        out_en = 1'b1; #1;
        chk(dout == 8'hA5, "R9 word restored", int'(dout), 8'hA5);
        pop(8'hA5);

        // R11: shift_out on an empty buffer
        shift_out = 1'b1;
        step(3);
        chk(out_rdy == 1'b0, "R11 empty strobe high", int'(out_rdy), 0);
        shift_out = 1'b0;
        step(DLY + 4);
        chk(out_rdy == 1'b0, "R11 empty strobe no effect", int'(out_rdy), 0);
        push(8'h5A);
        pop(8'h5A);

        // R7 R8: held write against a full buffer
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        din = 8'hC3; shift_in = 1'b1;
        step(10);
        chk(in_rdy == 1'b0, "R7 full holds in_rdy low", int'(in_rdy), 0);
        pop(8'h01);
        step(4);
        chk(in_rdy == 1'b0, "R8 held word captured", int'(in_rdy), 0);
        shift_in = 1'b0;
        step(DLY + 4);
        q.push_back(8'hC3);
        chk(in_rdy == 1'b0, "R8 full again after capture", int'(in_rdy), 0);
        pop(8'h02); pop(8'h03); pop(8'h04); pop(8'hC3);

        // R1: reset in the middle of operation
        push(8'h99);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        q.delete();
        chk(in_rdy == 1'b1 && out_rdy == 1'b0 && dout == '0, "R1 mid-run reset",
            int'({in_rdy, out_rdy}), 2);
        push(8'h77);
        pop(8'h77);

        finish_run();
    end

endmodule